// File: doc/BRIEF.md
# Three-Level Hysteresis Current Modulator

This block closes the fast current loop of one phase of a three-level clamped inverter leg. Each time a new sample pair arrives it subtracts the measured current from the requested current. It compares the difference against two nested bands on each side of zero: a wide outer band and a narrow inner dead band. From that comparison it decides whether the leg should output its positive level, its mid level or its negative level.

The chosen level is then turned into gate enables for one of three leg structures: a diode-clamped four-switch leg, a T-type leg whose mid path is a back-to-back switch pair, and an active-clamped six-switch leg. The active-clamped leg has several ways to make the mid level, and a small configuration field picks one of them. The level state and all gate enables are registered, so every gate moves on the same clock edge. Reference generation, DC-link regulation and capacitor balancing happen outside this block.

Top module: `hyst_leg_modulator`

## Requirements
- R1: On an accepted sample with error e = i_ref - i_meas > 0, the level becomes +1 when e >= band_outer. It becomes 0 when e <= band_inner. Otherwise it holds. All comparisons are signed and inclusive, and e is formed at 17 bits so that it cannot overflow.
- R2: On an accepted sample with e < 0, the level becomes -1 when e <= -band_outer. It becomes 0 when e >= -band_inner. Otherwise it holds.
- R3: On an accepted sample with e = 0, the level becomes 0.
- R4: The level never moves between +1 and -1 in a single step. When the comparison asks for the opposite active level, the level goes to 0 on that sample instead.
- R5: The level and the gates change only on a clock edge where smp_vld is 1 or leg_sel differs from the leg type in use. They show the result one edge after the sample is accepted.
- R6: Level encoding on `level` is 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. For leg_sel 0 (diode-clamped, gate bits 0..3 drive switches 1..4 from top to bottom), the gates are: +1 = 6'b000011, 0 = 6'b000110, -1 = 6'b001100.
- R7: For leg_sel 1 (T-type: bit 0 is the upper switch, bits 1 and 2 are the two mid devices, bit 3 is the lower switch), the gates are: +1 = 6'b000001, 0 = 6'b000110, -1 = 6'b001000. Exactly one gate is on in each active level.
- R8: For leg_sel 2 (active-clamped: bits 0..5 drive switches 1..6), +1 = 6'b000011 and -1 = 6'b001100. The 0 level follows zero_sel: 0 gives 6'b010010, 1 gives 6'b000010, 2 gives 6'b100100 and 3 gives 6'b000100.
- R9: After reset the level is 0 and all gates are off. The gates stay off until the first sample is accepted.
- R10: After reset the leg type in use is 0. When leg_sel differs from the leg type in use, the next edge adopts the new type and forces level 0, and any sample on that edge is dropped. If a sample has already been accepted since reset, that edge also drives the new type's zero pattern onto the gates.
- R11: leg_sel 3 is reserved. With it, all gates are off while the level keeps tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | A new sample pair is present |
| i_ref | input | 16 | Requested current, signed |
| i_meas | input | 16 | Measured current, signed |
| band_outer | input | 16 | Outer band magnitude, unsigned |
| band_inner | input | 16 | Dead band magnitude, unsigned, below band_outer |
| leg_sel | input | 2 | Leg type: 0 diode-clamped, 1 T-type, 2 active-clamped, 3 reserved |
| zero_sel | input | 2 | Mid-level pattern for the active-clamped leg |
| gate | output | 6 | Registered gate enables |
| level | output | 2 | Present level, two's complement |

## Verification
The hardest case to reach is a reversal of the error that is strong enough to demand the opposite active level. The stimulus drives the leg to +1 and then presents an error below -band_outer, which must land on 0. It repeats the same error to show that the next sample reaches -1, and runs the mirror sequence from -1. A second hard case is a change of leg_sel made while an active level is held. The bench makes this change with a sample strobe present on the same edge, to show that the forced zero wins. Full-scale opposite inputs check that the 17-bit error does not wrap.

// File: rtl/hyst_leg_modulator.sv
module hyst_leg_modulator #(
  parameter int W  = 16,
  parameter int NG = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [W-1:0]  i_ref,
  input  logic [W-1:0]  i_meas,
  input  logic [W-1:0]  band_outer,
  input  logic [W-1:0]  band_inner,
  input  logic [1:0]    leg_sel,
  input  logic [1:0]    zero_sel,
  output logic [NG-1:0] gate,
  output logic [1:0]    level
);
  localparam int EW = W + 1;
  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_POS  = 2'b01;
  localparam logic [1:0] LV_NEG  = 2'b11;

  logic signed [EW-1:0] err, h_x, d_x;
  logic [1:0] lvl_q, tgt, lvl_n, leg_q;
  logic [NG-1:0] gate_q;
  logic armed;
  logic leg_chg;

  assign err = $signed({i_ref[W-1], i_ref}) - $signed({i_meas[W-1], i_meas});
  assign h_x = $signed({1'b0, band_outer});
  assign d_x = $signed({1'b0, band_inner});
  assign leg_chg = (leg_sel != leg_q);

  always_comb begin
    tgt = lvl_q;
    if (err > 0) begin
      if (err >= h_x)      tgt = LV_POS;
      else if (err <= d_x) tgt = LV_ZERO;
    end else if (err < 0) begin
      if (err <= -h_x)      tgt = LV_NEG;
      else if (err >= -d_x) tgt = LV_ZERO;
    end else begin
      tgt = LV_ZERO;
    end
  end

  assign lvl_n = ((lvl_q == LV_POS && tgt == LV_NEG) ||
                  (lvl_q == LV_NEG && tgt == LV_POS)) ? LV_ZERO : tgt;

  function automatic logic [NG-1:0] decode(input logic [1:0] lv,
                                           input logic [1:0] lg,
                                           input logic [1:0] zs);
    logic [NG-1:0] g;
    g = '0;
    case (lg)
      2'd0: case (lv)
              LV_POS:  g = 6'b000011;
              LV_NEG:  g = 6'b001100;
              default: g = 6'b000110;
            endcase
      2'd1: case (lv)
              LV_POS:  g = 6'b000001;
              LV_NEG:  g = 6'b001000;
              default: g = 6'b000110;
            endcase
      2'd2: case (lv)
              LV_POS:  g = 6'b000011;
              LV_NEG:  g = 6'b001100;
              default: case (zs)
                         2'd0:    g = 6'b010010;
                         2'd1:    g = 6'b000010;
                         2'd2:    g = 6'b100100;
                         default: g = 6'b000100;
                       endcase
            endcase
      default: g = '0;
    endcase
    return g;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LV_ZERO;
      leg_q  <= 2'd0;
      gate_q <= '0;
      armed  <= 1'b0;
    end else if (leg_chg) begin
      lvl_q <= LV_ZERO;
      leg_q <= leg_sel;
      if (armed) gate_q <= decode(LV_ZERO, leg_sel, zero_sel);
    end else if (smp_vld) begin
      lvl_q  <= lvl_n;
      armed  <= 1'b1;
      gate_q <= decode(lvl_n, leg_q, zero_sel);
    end
  end

  assign gate  = gate_q;
  assign level = lvl_q;

  p_pos_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !leg_chg && err >= h_x && h_x > 0 && lvl_q != LV_NEG) |=> level == LV_POS);

  p_neg_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !leg_chg && err <= -h_x && h_x > 0 && lvl_q != LV_POS) |=> level == LV_NEG);

  p_no_flip_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LV_NEG) |=> (level != LV_POS));

  p_no_flip_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LV_POS) |=> (level != LV_NEG));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !leg_chg) |=> ($stable(level) && $stable(gate)));

  p_tt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_q == 2'd1 && level != LV_ZERO) |-> $countones(gate) == 1);

  p_leg_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    leg_chg |=> level == LV_ZERO);

  p_reserved_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_q == 2'd3) |-> gate == '0);
endmodule

// File: tb/sim_hyst_leg_modulator.sv
module sim_hyst_leg_modulator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [15:0] i_ref = '0, i_meas = '0;
  logic [15:0] band_outer = 16'd210, band_inner = 16'd50;
  logic [1:0] leg_sel = 2'd0, zero_sel = 2'd0;
  logic [5:0] gate;
  logic [1:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string tag_q[$];

  int m_lvl = 0;
  int m_leg = 0;
  bit m_armed = 1'b0;
  logic [5:0] m_gate = '0;

  hyst_leg_modulator u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .i_ref(i_ref), .i_meas(i_meas),
    .band_outer(band_outer), .band_inner(band_inner), .leg_sel(leg_sel),
    .zero_sel(zero_sel), .gate(gate), .level(level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] enc(input int lv);
    return lv > 0 ? 2'b01 : (lv < 0 ? 2'b11 : 2'b00);
  endfunction

  function automatic logic [5:0] pattern(input int lv, input int lg, input int zs);
    if (lg == 0) return lv > 0 ? 6'b000011 : (lv < 0 ? 6'b001100 : 6'b000110);
    if (lg == 1) return lv > 0 ? 6'b000001 : (lv < 0 ? 6'b001000 : 6'b000110);
    if (lg == 2) begin
      if (lv > 0) return 6'b000011;
      if (lv < 0) return 6'b001100;
      case (zs)
        0: return 6'b010010;
        1: return 6'b000010;
        2: return 6'b100100;
        default: return 6'b000100;
      endcase
    end
    return 6'b000000;
  endfunction

  task automatic step(input int rv, input int mv, input bit vld,
                      input int lg, input int zs, input string tag);
    int e, t;
    @(negedge clk);
    i_ref = rv[15:0]; i_meas = mv[15:0]; smp_vld = vld;
    leg_sel = lg[1:0]; zero_sel = zs[1:0];
    if (lg != m_leg) begin
      m_lvl = 0; m_leg = lg;
      if (m_armed) m_gate = pattern(0, lg, zs);
    end else if (vld) begin
      e = rv - mv;
      t = m_lvl;
      if (e > 0) begin
        if (e >= int'(band_outer)) t = 1;
        else if (e <= int'(band_inner)) t = 0;
      end else if (e < 0) begin
        if (e <= -int'(band_outer)) t = -1;
        else if (e >= -int'(band_inner)) t = 0;
      end else t = 0;
      if (t * m_lvl < 0) t = 0;
      m_lvl = t; m_armed = 1'b1;
      m_gate = pattern(t, lg, zs);
    end
    exp_q.push_back({enc(m_lvl), m_gate});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    logic [7:0] ex;
    string tg;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if ({level, gate} !== ex) begin
          errors++;
          $display("FAIL %s actual level=%b gate=%b expected level=%b gate=%b",
                   tg, level, gate, ex[7:6], ex[5:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (level !== 2'b00 || gate !== 6'b0) begin
      errors++;
      $display("FAIL R9 in reset actual level=%b gate=%b expected 00/000000", level, gate);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R9 idle after reset");
    step(500, 0, 0, 0, 0, "R9 no strobe keeps gates off");
    step(0, 0, 1, 0, 0, "R9 first sample gives zero pattern");
    // diode-clamped leg
    step(300, 0, 1, 0, 0, "R1 R6 err above outer -> +1");
    step(100, 0, 1, 0, 0, "R1 between bands holds +1");
    step(210, 0, 1, 0, 0, "R1 err equal outer stays +1");
    step(50, 0, 1, 0, 0, "R1 err equal inner -> 0");
    step(-100, 0, 1, 0, 0, "R2 negative between bands holds 0");
    step(0, 210, 1, 0, 0, "R2 R6 err equal -outer -> -1");
    step(-60, 0, 1, 0, 0, "R2 between bands holds -1");
    step(-50, 0, 1, 0, 0, "R2 err equal -inner -> 0");
    step(250, 0, 1, 0, 0, "R1 back to +1");
    step(0, 0, 1, 0, 0, "R3 zero error -> 0");
    step(250, 0, 1, 0, 0, "R1 +1 again");
    step(-300, 0, 1, 0, 0, "R4 reversal lands on 0");
    step(-300, 0, 1, 0, 0, "R4 next sample reaches -1");
    step(300, 0, 1, 0, 0, "R4 reversal from -1 lands on 0");
    step(300, 0, 1, 0, 0, "R4 next sample reaches +1");
    step(-300, 0, 0, 0, 0, "R5 no strobe holds");
    step(0, 0, 0, 0, 0, "R5 no strobe holds again");
    step(32767, -32768, 1, 0, 0, "R1 full-scale error no wrap");
    // leg change while +1, sample present
    step(-300, 0, 1, 1, 0, "R10 leg change forces 0, sample dropped");
    step(300, 0, 1, 1, 0, "R7 T-type +1");
    step(-300, 0, 1, 1, 0, "R7 T-type via 0");
    step(-300, 0, 1, 1, 0, "R7 T-type -1");
    step(-20, 0, 1, 1, 0, "R7 T-type zero");
    // active-clamped
    step(0, 0, 0, 2, 0, "R10 change to active-clamped");
    step(300, 0, 1, 2, 0, "R8 +1");
    step(0, 0, 1, 2, 1, "R8 zero sel 1");
    step(0, 0, 1, 2, 2, "R8 zero sel 2");
    step(0, 0, 1, 2, 3, "R8 zero sel 3");
    step(-32768, 32767, 1, 2, 0, "R8 -1 full scale");
    step(0, 0, 1, 2, 0, "R8 zero sel 0");
    // reserved
    step(300, 0, 1, 3, 0, "R10 R11 change to reserved");
    step(300, 0, 1, 3, 0, "R11 reserved gates off at +1");
    step(300, 0, 1, 0, 0, "R10 back to diode-clamped zero");
    step(300, 0, 1, 0, 0, "R6 +1 after return");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule